// File: doc/BRIEF.md
# Inverse 5/3 Lifting Row Reconstructor

This block rebuilds one row of image samples from its one-dimensional integer 5/3 wavelet coefficients. Coefficients arrive as a single stream of interleaved pairs: a low-pass value followed by a high-pass value for each pair index. A valid strobe marks each coefficient. A start marker on the first low-pass value and an end marker on the last high-pass value bound each row. The block first removes the update step to get each even sample. It then removes the predict step to get each odd sample. Samples come out in natural order, one per cycle, under an output valid flag.

Scaling by one quarter and one half is done by arithmetic shifts inside a single processing element. This element serves both lifting steps. The β step takes it on high-pass beats. The α step takes it on low-pass beats and in the tail cycles after a row ends. Rounding is floor-based and matches the reversible forward transform, so the reconstruction is bit-exact. The block is meant to sit behind a column pass in a two-dimensional inverse transform, once per row.

Top module: `inv_lift53_row`

## Requirements
- R1: While reset is held, and after it until the first output is due, `outValid` stays low.
- R2: The first coefficient of a row (marked by `rowFirst`) is low-pass L(0), and the stream alternates low, high. Each even sample is x(2j) = L(j) − floor((H(j−1) + H(j) + 2) / 4).
- R3: At the left edge, H(−1) is replaced by H(0) when forming x(0).
- R4: Each odd sample is x(2j+1) = H(j) + floor((x(2j) + x(2j+2)) / 2).
- R5: At the right edge, x(2M) is replaced by x(2M−2), so the last sample is x(2M−1) = H(M−1) + x(2M−2).
- R6: A row of M pairs yields exactly 2M samples, x(0) first and in ascending order. Each sample is a two's-complement value of SAMPLE_W bits on `outData`, equal bit for bit to the row the forward transform was applied to.
- R7: A beat that produces a sample shows it on the outputs after the same clock edge that captured the beat. The last sample of a row appears after the third clock edge following the edge that captured the `rowLast` beat. The two samples before it come out in the two cycles just before the last one, with no gaps.
- R8: Idle cycles inserted anywhere inside a row do not change the samples produced.
- R9: A one-pair row (2 samples) is reconstructed with both edge rules applied to the same pair.
- R10: No coefficient may be presented in the three cycles after a `rowLast` beat.
- R11: With no input beat and no tail cycle pending, no sample is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Coefficient present on `inData` |
| inData | input | COEF_W | Signed coefficient, low-pass and high-pass interleaved |
| rowFirst | input | 1 | Marks L(0), the first coefficient of a row |
| rowLast | input | 1 | Marks H(M−1), the last coefficient of a row |
| outValid | output | 1 | Reconstructed sample present on `outData` |
| outData | output | SAMPLE_W | Signed reconstructed sample |

## Verification
The right-edge tail and the left-edge substitution can act on the same coefficient pair. In the same row the tail's leading odd step is either used or skipped, depending on whether the row has one pair or more. Directed one-pair and two-pair rows with extreme and alternating values force these overlaps. Random row lengths down to one pair, with and without idle gaps, provoke them further. Every sample is judged against the original row. The bench also checks the sample count and the cycle of the final sample relative to the row's last beat.

// File: rtl/irow_pkg.sv
package irow_pkg;

  typedef enum logic [1:0] {
    TAIL_IDLE = 2'd0,
    TAIL_ODD  = 2'd1,
    TAIL_EVEN = 2'd2,
    TAIL_LAST = 2'd3
  } tail_e;

  typedef struct packed {
    logic loadL;      // capture a low-pass coefficient
    logic betaStep;   // PE runs the update-removal step
    logic edgeLeft;   // use H(0) in place of H(-1)
    logic alphaStep;  // PE runs the predict-removal step, result is emitted
    logic edgeRight;  // use x(2M-2) in place of x(2M)
    logic emitEven;   // emit the held even sample
  } strobe_t;

endpackage

// File: rtl/lift_pe.sv
module lift_pe #(
  parameter int W = 14
) (
  input  logic                betaMode,
  input  logic signed [W-1:0] base,
  input  logic signed [W-1:0] opA,
  input  logic signed [W-1:0] opB,
  output logic signed [W-1:0] res
);
  logic signed [W:0] sum;

  always_comb begin
    sum = $signed({opA[W-1], opA}) + $signed({opB[W-1], opB})
        + $signed({{(W-1){1'b0}}, betaMode, 1'b0});
    if (betaMode) res = base - W'(sum >>> 2);
    else          res = base + W'(sum >>> 1);
  end
endmodule

// File: rtl/irow_ctrl.sv
module irow_ctrl
  import irow_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    rowFirst,
  input  logic    rowLast,
  output strobe_t stb,
  output logic    tailBusy
);
  logic       phase;
  logic [1:0] hCnt;
  logic [1:0] hcEff;
  tail_e      tail;
  logic       isH, beatL, beatH;

  always_comb begin
    isH   = rowFirst ? 1'b0 : phase;
    beatL = inValid && !isH;
    beatH = inValid && isH;
    hcEff = (inValid && rowFirst) ? 2'd0 : hCnt;
    stb           = '0;
    stb.loadL     = beatL;
    stb.betaStep  = beatH;
    stb.edgeLeft  = beatH && (hcEff == 2'd0);
    stb.alphaStep = (beatL && hcEff == 2'd2)
                 || (tail == TAIL_ODD && hCnt == 2'd2)
                 || (tail == TAIL_LAST);
    stb.edgeRight = (tail == TAIL_LAST);
    stb.emitEven  = (beatH && hcEff != 2'd0) || (tail == TAIL_EVEN);
    tailBusy      = (tail != TAIL_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= 1'b0;
      hCnt  <= 2'd0;
      tail  <= TAIL_IDLE;
    end else begin
      if (inValid) phase <= !isH;
      if (beatH)                hCnt <= (hcEff == 2'd2) ? 2'd2 : hcEff + 2'd1;
      else if (beatL && rowFirst) hCnt <= 2'd0;
      if (beatH && rowLast) tail <= TAIL_ODD;
      else begin
        case (tail)
          TAIL_ODD:  tail <= TAIL_EVEN;
          TAIL_EVEN: tail <= TAIL_LAST;
          default:   tail <= TAIL_IDLE;
        endcase
      end
    end
  end

  // R10: the tail owns the PE and the pipeline registers
  a_r10_no_beat_in_tail: assert property (@(posedge clk) disable iff (!rstN)
    tailBusy |-> !inValid);
endmodule

// File: rtl/irow_datapath.sv
module irow_datapath
  import irow_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [COEF_W-1:0]   inData,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outData
);
  localparam int AW = COEF_W + 2;

  logic signed [AW-1:0] inExt;
  logic signed [AW-1:0] lReg, hOld, hCur, evenOld, evenCur;
  logic signed [AW-1:0] peBase, peA, peB, peRes;

  assign inExt = AW'($signed(inData));

  always_comb begin
    if (stb.betaStep) begin
      peBase = lReg;
      peA    = stb.edgeLeft ? inExt : hCur;
      peB    = inExt;
    end else begin
      peBase = stb.edgeRight ? hCur : hOld;
      peA    = stb.edgeRight ? evenCur : evenOld;
      peB    = evenCur;
    end
  end

  lift_pe #(.W(AW)) u_pe (
    .betaMode (stb.betaStep),
    .base     (peBase),
    .opA      (peA),
    .opB      (peB),
    .res      (peRes)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lReg     <= '0;
      hOld     <= '0;
      hCur     <= '0;
      evenOld  <= '0;
      evenCur  <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (stb.loadL) lReg <= inExt;
      if (stb.betaStep) begin
        hOld    <= hCur;
        hCur    <= inExt;
        evenOld <= evenCur;
        evenCur <= peRes;
      end
      outValid <= stb.alphaStep || stb.emitEven;
      if (stb.alphaStep)     outData <= SAMPLE_W'(peRes);
      else if (stb.emitEven) outData <= SAMPLE_W'(evenCur);
    end
  end

  // R2: one shared PE, never asked for both steps at once
  a_r2_pe_shared: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.betaStep && stb.alphaStep));
  // R6: an emitted odd sample fits the sample width for well-formed input
  a_r6_odd_in_range: assert property (@(posedge clk) disable iff (!rstN)
    stb.alphaStep |-> (peRes == AW'($signed(peRes[SAMPLE_W-1:0]))));
endmodule

// File: rtl/inv_lift53_row.sv
module inv_lift53_row
  import irow_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = SAMPLE_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [COEF_W-1:0]   inData,
  input  logic                rowFirst,
  input  logic                rowLast,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outData
);
  strobe_t stb;
  logic    tailBusy;

  irow_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rowFirst (rowFirst),
    .rowLast  (rowLast),
    .stb      (stb),
    .tailBusy (tailBusy)
  );

  irow_datapath #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

  // R7: the tail yields two more samples and then goes quiet
  a_r7_tail_timing: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && rowLast) |=> ##2 outValid ##1 outValid ##1 !outValid);
  // R11: nothing comes out without a beat or a tail cycle
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !tailBusy) |=> !outValid);
  // R1: quiet straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !outValid);
endmodule

// File: tb/inv_lift53_row_tb.sv
`timescale 1ns/1ps
module inv_lift53_row_tb;
  localparam int SW = 10;
  localparam int CW = SW + 2;
  localparam int XMAX = (1 << (SW - 1)) - 1;
  localparam int XMIN = -(1 << (SW - 1));

  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, rowFirst = 1'b0, rowLast = 1'b0;
  logic [CW-1:0] inData = '0;
  logic          outValid;
  logic [SW-1:0] outData;

  always #2.5 clk = ~clk;

  inv_lift53_row #(.SAMPLE_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .rowFirst(rowFirst), .rowLast(rowLast), .outValid(outValid), .outData(outData)
  );

  int total = 0, bad = 0, cyc = 0, lastBeatCyc = 0;
  int gotVal[$];
  int gotCyc[$];
  int xs[64];
  int hs[32];
  int ls[32];

  always @(negedge clk) begin
    if (rstN && outValid) begin
      gotVal.push_back(int'($signed(outData)));
      gotCyc.push_back(cyc);
    end
    cyc++;
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void forward(int m);
    for (int i = 0; i < m; i++) begin
      int xr;
      xr = (i == m - 1) ? xs[2*i] : xs[2*i+2];
      hs[i] = xs[2*i+1] - ((xs[2*i] + xr) >>> 1);
    end
    for (int i = 0; i < m; i++) begin
      int hp;
      hp = (i == 0) ? hs[0] : hs[i-1];
      ls[i] = xs[2*i] + ((hp + hs[i] + 2) >>> 2);
    end
  endfunction

  task automatic beat(int v, bit first, bit last);
    @(posedge clk); #1;
    inValid = 1'b1; inData = CW'(v); rowFirst = first; rowLast = last;
    lastBeatCyc = cyc;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    inValid = 1'b0; rowFirst = 1'b0; rowLast = 1'b0;
  endtask

  task automatic sendRow(int m, int pat, bit gaps);
    int n;
    string tag;
    for (int k = 0; k < 2 * m; k++) begin
      case (pat)
        1: xs[k] = XMAX;
        2: xs[k] = XMIN;
        3: xs[k] = (k % 2) ? XMAX : XMIN;
        4: xs[k] = (k % 2) ? XMIN : XMAX;
        default: xs[k] = int'($urandom_range(0, (1 << SW) - 1)) + XMIN;
      endcase
    end
    forward(m);
    gotVal.delete();
    gotCyc.delete();
    for (int i = 0; i < m; i++) begin
      if (gaps && $urandom_range(0, 3) == 0) idle();
      beat(ls[i], i == 0, 1'b0);
      if (gaps && $urandom_range(0, 3) == 0) idle();
      beat(hs[i], 1'b0, i == m - 1);
    end
    idle();
    repeat (7) @(posedge clk);
    n = gotVal.size();
    check(n == 2 * m, (m == 1) ? "R9" : "R6", "sample count", n, 2 * m);
    for (int k = 0; k < n && k < 2 * m; k++) begin
      if (m == 1)             tag = "R9";
      else if (k == 0)        tag = "R3";
      else if (k == 2*m - 1)  tag = "R5";
      else if (gaps)          tag = "R8";
      else if (k % 2)         tag = "R4";
      else                    tag = "R2";
      check(gotVal[k] == xs[k], tag, $sformatf("sample %0d of %0d-pair row", k, m),
            gotVal[k], xs[k]);
    end
    if (n > 0)
      check(gotCyc[n-1] - lastBeatCyc == 4, "R7", "last sample cycle offset",
            gotCyc[n-1] - lastBeatCyc, 4);
    repeat (5) @(posedge clk);
    check(gotVal.size() == n, "R11", "samples while idle", gotVal.size(), n);
  endtask

  task automatic runAll();
    repeat (3) @(negedge clk) check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk) check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    sendRow(1, 1, 1'b0);
    sendRow(1, 2, 1'b0);
    sendRow(1, 3, 1'b0);
    sendRow(1, 0, 1'b0);
    sendRow(2, 3, 1'b0);
    sendRow(2, 4, 1'b0);
    sendRow(2, 0, 1'b1);
    sendRow(16, 3, 1'b0);
    sendRow(16, 4, 1'b1);
    sendRow(16, 1, 1'b0);
    sendRow(16, 2, 1'b0);
    for (int r = 0; r < 40; r++)
      sendRow(int'($urandom_range(1, 16)), 0, r[0]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule